// File: doc/BRIEF.md
# Message-Injecting Modular Combine Stage

This block performs the last combine step of a lattice encryption pass. It sweeps once over a polynomial of 256 coefficients. For each coefficient it reads an accumulated partial sum from one RAM bank and a noise coefficient from a second bank. It adds a message term: half of the modulus when the matching message bit is set, and zero otherwise. It reduces the result modulo q = 3329 and writes it back over the partial-sum entry it came from.

Both banks are synchronous RAMs with one cycle of read latency, driven with the same index. Because the partial sum and the noise live in separate banks, the two reads never share a port. A pulse on `start_i` while the block is idle launches a sweep.

The read index advances one step per cycle. The matching write follows one cycle later and carries a registered valid flag and index. The message bit is selected by that registered write index. `done_o` pulses once after the final coefficient has been written.

Top module: `msg_inject_add`

## Requirements
- R1: After reset is released and before any start, `wr_en_o` and `done_o` are 0 and both read addresses are 0.
- R2: A `start_i` pulse seen at a clock edge while idle begins a sweep. In the n-th cycle after that edge (n = 0..255), both `psum_raddr_o` and `noise_raddr_o` equal n.
- R3: Each write comes exactly one cycle after its read address. `wr_en_o` is high for 256 consecutive cycles (n = 1..256), and `wr_addr_o` equals the read index presented in the cycle before.
- R4: The written value is (psum + e2 + mu) mod 3329. Here mu is 1665 when bit w of `msg_i` is 1 and 0 when it is 0, with bit 0 belonging to coefficient 0 and bit w selected by the write index w.
- R5: For operands below 3329, every written value is below 3329, including the largest sum 3328 + 3328 + 1665 = 8321, which gives 1663.
- R6: The result is written into the partial-sum bank at the same index it was read from. After a sweep, that bank holds the combined polynomial.
- R7: `done_o` is a single-cycle pulse in the cycle after the write of coefficient 255 (n = 257), and no write occurs in or after that cycle until the next start.
- R8: A `start_i` pulse during a sweep has no effect on addresses, writes or the timing of `done_o`.

Both R4 and R5 refer to coefficient and message-bit index w; q = 3329 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a sweep when idle |
| msg_i | input | 256 | Message bits, bit w for coefficient w |
| psum_rdata_i | input | 12 | Partial-sum bank read data (1-cycle latency) |
| noise_rdata_i | input | 12 | Noise bank read data (1-cycle latency) |
| psum_raddr_o | output | 8 | Partial-sum bank read address |
| noise_raddr_o | output | 8 | Noise bank read address |
| wr_en_o | output | 1 | Partial-sum bank write enable |
| wr_addr_o | output | 8 | Partial-sum bank write address |
| wr_data_o | output | 12 | Reduced result |
| done_o | output | 1 | One-cycle pulse at sweep end |

## Verification
A write index that drifts from its read index shows up in the very next write. A neighbouring coefficient's value lands in the slot, or the message bit of the wrong position is applied, so the per-cycle model comparison flags it on the first affected write. A reduction fault appears only for operand sums at or above q or 2q, so the stimulus includes maximum-valued operands with all message bits set, and exact multiples of q. A control fault, such as a missed valid drop or a restart taken mid-sweep, moves `done_o` or adds a stray write within one cycle of the final coefficient.

// File: rtl/mi_pkg.sv
package mi_pkg;
  parameter int N      = 256;
  parameter int Q      = 3329;
  parameter int MU_VAL = 1665;
  parameter int CW     = 12;
  parameter int SW     = 14;
  parameter int NSUB   = 2;
  parameter int IW     = $clog2(N);
endpackage

// File: rtl/mi_sweep_ctrl.sv
module mi_sweep_ctrl #(
  parameter int N  = mi_pkg::N,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [IW-1:0] rd_idx_o,
  output logic          wr_vld_o,
  output logic [IW-1:0] wr_idx_o,
  output logic          done_o
);
  localparam logic [IW:0]   LIMIT = (IW+1)'(N);
  localparam logic [IW-1:0] LAST  = IW'(N-1);

  logic [IW:0]   rd_q;
  logic          busy_q, vld_q, done_q;
  logic [IW-1:0] widx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      widx_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          rd_q   <= '0;
        end
      end else begin
        if (rd_q < LIMIT) begin
          rd_q   <= rd_q + 1'b1;
          vld_q  <= 1'b1;
          widx_q <= rd_q[IW-1:0];
        end else begin
          vld_q <= 1'b0;
        end
        // last coefficient commits this cycle
        if (vld_q && widx_q == LAST) begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign rd_idx_o = rd_q[IW-1:0];
  assign wr_vld_o = vld_q;
  assign wr_idx_o = widx_q;
  assign done_o   = done_q;
endmodule

// File: rtl/mi_mu_sel.sv
module mi_mu_sel #(
  parameter int N      = mi_pkg::N,
  parameter int CW     = mi_pkg::CW,
  parameter int MU_VAL = mi_pkg::MU_VAL,
  parameter int IW     = $clog2(N)
) (
  input  logic [N-1:0]  msg_i,
  input  logic [IW-1:0] idx_i,
  output logic [CW-1:0] mu_o
);
  localparam logic [CW-1:0] MU_C = CW'(MU_VAL);
  assign mu_o = msg_i[idx_i] ? MU_C : '0;
endmodule

// File: rtl/mi_modadd3.sv
module mi_modadd3 #(
  parameter int Q    = mi_pkg::Q,
  parameter int CW   = mi_pkg::CW,
  parameter int SW   = mi_pkg::SW,
  parameter int NSUB = mi_pkg::NSUB
) (
  input  logic [CW-1:0] a_i,
  input  logic [CW-1:0] b_i,
  input  logic [CW-1:0] c_i,
  output logic [CW-1:0] r_o
);
  localparam logic [SW-1:0] QS = SW'(Q);

  logic [SW-1:0] stg [NSUB+1];

  assign stg[0] = SW'(a_i) + SW'(b_i) + SW'(c_i);

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    assign stg[g+1] = (stg[g] >= QS) ? (stg[g] - QS) : stg[g];
  end

  assign r_o = stg[NSUB][CW-1:0];
endmodule

// File: rtl/msg_inject_add.sv
module msg_inject_add #(
  parameter int N      = mi_pkg::N,
  parameter int Q      = mi_pkg::Q,
  parameter int MU_VAL = mi_pkg::MU_VAL,
  parameter int CW     = mi_pkg::CW,
  parameter int SW     = mi_pkg::SW,
  parameter int NSUB   = mi_pkg::NSUB,
  parameter int IW     = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]  msg_i,
  input  logic [CW-1:0] psum_rdata_i,
  input  logic [CW-1:0] noise_rdata_i,
  output logic [IW-1:0] psum_raddr_o,
  output logic [IW-1:0] noise_raddr_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_addr_o,
  output logic [CW-1:0] wr_data_o,
  output logic          done_o
);
  logic [IW-1:0] rd_idx, wr_idx;
  logic          wr_vld;
  logic [CW-1:0] mu;

  mi_sweep_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .rd_idx_o (rd_idx),
    .wr_vld_o (wr_vld),
    .wr_idx_o (wr_idx),
    .done_o   (done_o)
  );

  // message term follows the write index (data arrives one cycle late)
  mi_mu_sel #(.N(N), .CW(CW), .MU_VAL(MU_VAL), .IW(IW)) u_mu (
    .msg_i (msg_i),
    .idx_i (wr_idx),
    .mu_o  (mu)
  );

  mi_modadd3 #(.Q(Q), .CW(CW), .SW(SW), .NSUB(NSUB)) u_add (
    .a_i (psum_rdata_i),
    .b_i (noise_rdata_i),
    .c_i (mu),
    .r_o (wr_data_o)
  );

  assign psum_raddr_o  = rd_idx;
  assign noise_raddr_o = rd_idx;
  assign wr_en_o       = wr_vld;
  assign wr_addr_o     = wr_idx;
endmodule

// File: rtl/msg_inject_add_chk.sv
module msg_inject_add_chk #(
  parameter int N  = mi_pkg::N,
  parameter int Q  = mi_pkg::Q,
  parameter int CW = mi_pkg::CW,
  parameter int IW = $clog2(N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [IW-1:0] psum_raddr_o,
  input logic          wr_en_o,
  input logic [IW-1:0] wr_addr_o,
  input logic [CW-1:0] wr_data_o,
  input logic          done_o
);
  localparam logic [IW-1:0] LAST = IW'(N-1);

  AST_WR_TRAILS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_addr_o == $past(psum_raddr_o)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o != LAST) |=> (wr_en_o && wr_addr_o == $past(wr_addr_o) + 1'b1)); // R3
  AST_BELOW_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_data_o < CW'(Q)); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(wr_en_o) && $past(wr_addr_o) == LAST)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_NO_WR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_en_o); // R7
endmodule

bind msg_inject_add msg_inject_add_chk #(.N(N), .Q(Q), .CW(CW), .IW(IW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .psum_raddr_o (psum_raddr_o),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .done_o       (done_o)
);

// File: tb/tb_msg_inject_add.sv
`timescale 1ns/1ps
module tb_msg_inject_add;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] msg = '0;
  logic [11:0]  psum_rd, noise_rd;
  logic [7:0]   psum_ra, noise_ra, wr_addr;
  logic         wr_en, done;
  logic [11:0]  wr_data;

  logic [11:0] psum_mem  [256];
  logic [11:0] noise_mem [256];
  int          snap [256];
  int          cyc = -1;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  msg_inject_add dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .msg_i(msg),
    .psum_rdata_i(psum_rd), .noise_rdata_i(noise_rd),
    .psum_raddr_o(psum_ra), .noise_raddr_o(noise_ra),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .done_o(done)
  );

  // synchronous RAMs, one cycle read latency
  always @(posedge clk) begin
    psum_rd  <= psum_mem[psum_ra];
    noise_rd <= noise_mem[noise_ra];
    if (wr_en) psum_mem[wr_addr] <= wr_data;
  end

  // behavioural timeline: cyc = edges since the accepted start edge
  always @(posedge clk) begin
    if (!rst_n) cyc <= -1;
    else if ((cyc == -1 || cyc == 257) && start) cyc <= 0;
    else if (cyc == 257) cyc <= -1;
    else if (cyc >= 0) cyc <= cyc + 1;
  end

  function automatic int expect_val(int a);
    return (snap[a] + int'(noise_mem[a]) + (msg[a] ? 1665 : 0)) % 3329;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d (cyc=%0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cyc >= 0) begin
      if (cyc <= 255) begin
        chk("R2 psum_raddr", int'(psum_ra), cyc);
        chk("R2 noise_raddr", int'(noise_ra), cyc);
      end
      chk("R3 wr_en", int'(wr_en), (cyc >= 1 && cyc <= 256) ? 1 : 0);
      if (cyc >= 1 && cyc <= 256) begin
        chk("R3 wr_addr", int'(wr_addr), cyc - 1);
        chk("R4 wr_data", int'(wr_data), expect_val(cyc - 1));
      end
      chk("R7 done", int'(done), (cyc == 257) ? 1 : 0);
    end else if (rst_n) begin
      chk("R7 idle wr_en", int'(wr_en), 0);
      chk("R7 idle done", int'(done), 0);
    end
  end

  task automatic run_case(int mode, bit restart);
    for (int i = 0; i < 256; i++) begin
      case (mode)
        0: begin psum_mem[i] = 12'd0;    noise_mem[i] = 12'd0; end
        1: begin psum_mem[i] = 12'd3328; noise_mem[i] = 12'd3328; end
        2: begin psum_mem[i] = 12'd3328; noise_mem[i] = 12'd1665; end
        default: begin
          psum_mem[i]  = 12'($urandom % 3329);
          noise_mem[i] = 12'($urandom % 3329);
        end
      endcase
      snap[i] = int'(psum_mem[i]);
    end
    case (mode)
      0: msg = '0;
      1: msg = '1;
      2: msg = {128{2'b01}};
      default: msg = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endcase
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (100) @(negedge clk);
      start = 1'b1;  // R8: ignored mid-sweep
      @(negedge clk); start = 1'b0;
    end
    wait (cyc == -1);
    @(negedge clk);
    for (int i = 0; i < 256; i++) chk("R6 in-place result", int'(psum_mem[i]), expect_val(i));
    if (mode == 1) chk("R5 worst case 8321", int'(psum_mem[0]), 1663);
    if (mode == 2) begin
      chk("R5 sum 2q to 0", int'(psum_mem[0]), 0);
      chk("R5 sum q+1664", int'(psum_mem[1]), 1664);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset wr_en", int'(wr_en), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle wr_en", int'(wr_en), 0);
    chk("R1 idle done", int'(done), 0);
    chk("R1 idle psum_raddr", int'(psum_ra), 0);
    chk("R1 idle noise_raddr", int'(noise_ra), 0);
    run_case(0, 1'b0);
    run_case(1, 1'b0);
    run_case(2, 1'b0);
    run_case(3, 1'b0);
    run_case(3, 1'b1);
    run_case(3, 1'b0);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule